// File: doc/BRIEF.md
# Simultaneous-Sample Inertial ADC Sequencer

This block runs a six-channel analogue-to-digital converter whose channels all track and hold at the same moment and which returns its results over a shared 16-bit parallel bus. A free-running rate generator issues a trigger 100 times per second. Each trigger drops one common hold line, so all six sample-and-hold stages freeze at the same instant and conversion begins. The converter reports completion one channel pair at a time on three separate active-low done lines. For each pair the block then fetches two words with low-going select and read strobes. The finished frame goes out through a small output stream. The block also produces the converter's conversion clock.

Channels 0 to 2 carry three accelerations and channels 3 to 5 carry three angular rates. They are fetched in the fixed order 0 to 5: first pair A (channels 0, 1), then pair B (2, 3), then pair C (4, 5). The frame leaves on a valid/ready interface. `frm_valid` rises with a completed frame and stays high, with the data frozen, until the consumer asserts `frm_ready`. Whenever a frame is waiting, the sequencer starts no new conversion; a trigger that arrives then is counted as an overrun. A pair whose done line stays high too long aborts the frame and raises an error flag.

Top module: `sim_adc_sequencer`

## Requirements
- R1: A trigger pulse occurs every `TICK_DIV` clocks (100 Hz by default). When the sequencer is idle and no frame is waiting, `adc_hold_n` falls in the cycle after the trigger, so consecutive frame starts are exactly `TICK_DIV` clocks apart. After reset all strobes and `adc_hold_n` are high, `frm_valid`, `frm_done` and `err_timeout` are low, and `ovr_count` is 0.
- R2: `adc_hold_n` stays low for exactly `HOLD_MIN` clocks and is high again before the first select strobe of the frame. Select is never low while hold is low.
- R3: Pairs are served in order. `adc_eoc_n[0]` belongs to pair A, bit 1 to pair B and bit 2 to pair C. No strobe for a pair begins until that pair's bit has been seen low.
- R4: A complete frame has six select pulses and six read pulses. `adc_cs_n` and `adc_rd_n` go low together, each pulse is `STROBE_LEN` clocks long, and pulses are separated by at least one high clock.
- R5: Each word is taken from `adc_data` on the last low clock of its strobe. Channel k (0 to 5, read order A0, A1, B0, B1, C0, C1) lands in `frm_data[16k +: 16]`.
- R6: `frm_done` is a one-clock pulse. It is raised in the cycle where the sixth word appears and `frm_valid` rises.
- R7: While `frm_valid` is high and `frm_ready` is low, `frm_valid` and `frm_data` hold steady and no new frame starts. The frame is handed over on a clock where both are high, and `frm_valid` then drops.
- R8: If a pair's done bit stays high for `EOC_TIMEOUT` clocks in a row, the frame is abandoned. No further strobes are issued, `frm_done` does not pulse, `frm_data` keeps its previous frame, and `err_timeout` goes high. `err_timeout` clears when the next frame's hold falls.
- R9: A trigger that arrives while a frame is in progress, or while `frm_valid` is high, adds one to `ovr_count` (which saturates) and neither restarts nor starts a frame.
- R10: `adc_conv_clk` is a square wave with a period of `2*CONV_HALF` clocks (5 MHz from 250 MHz by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_eoc_n | input | 3 | Per-pair conversion done, active low (bit0 A, bit1 B, bit2 C) |
| adc_data | input | 16 | Converter parallel output bus |
| adc_hold_n | output | 1 | Common hold for all six channels, active low |
| adc_cs_n | output | 1 | Converter select strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_conv_clk | output | 1 | Converter conversion clock |
| frm_valid | output | 1 | Frame available on `frm_data` |
| frm_ready | input | 1 | Consumer accepts the frame |
| frm_data | output | 96 | Six 16-bit samples, channel k at bits 16k+15:16k |
| frm_done | output | 1 | One-clock pulse when a frame completes |
| err_timeout | output | 1 | Last frame aborted on done-line timeout |
| ovr_count | output | 8 | Saturating count of triggers that could not start a frame |

## Verification
The in-line assertions check these rules on every cycle: a hold fall always follows a trigger, the hold width, the exclusion of select against hold, no strobe while the current pair's done bit is high, frame data frozen under back-pressure, an abort that leaves the bus quiet, and a trigger that cannot restart a running frame. Only the bench scenarios can show the rest. These are the actual word values and where they land in the frame, the six-strobe count and pulse widths seen from outside, the exact start spacing, the timeout path leaving the previous frame in place, overrun counting across a long conversion and under a stalled consumer, and the conversion clock period.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_HOLD   = 3'd1,
    SQ_WAIT   = 3'd2,
    SQ_STROBE = 3'd3,
    SQ_GAP    = 3'd4
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/adcseq_rate_gen.sv
module adcseq_rate_gen #(
  parameter int DIV    = 4,
  parameter bit SQUARE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic out
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  generate
    if (SQUARE) begin : g_square
      logic lvl;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl <= 1'b0;
        else if (wrap) lvl <= ~lvl;
      end
      assign out = lvl;
    end else begin : g_pulse
      logic pls;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls <= 1'b0;
        else pls <= wrap;
      end
      assign out = pls;
    end
  endgenerate
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int N_CH        = 6,
  parameter int HOLD_MIN    = 4,
  parameter int EOC_TIMEOUT = 2000,
  parameter int STROBE_LEN  = 3,
  parameter int OVR_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       occupied,
  input  logic [N_CH/2-1:0]          eoc_n,
  output logic                       hold_n,
  output logic                       cs_n,
  output logic                       rd_n,
  output logic                       cap_en,
  output logic [$clog2(N_CH)-1:0]    cap_idx,
  output logic                       err_timeout,
  output logic [OVR_W-1:0]           ovr_count
);
  localparam int N_PAIR  = N_CH / 2;
  localparam int CH_W    = $clog2(N_CH);
  localparam int CNT_MAX = max3(HOLD_MIN, EOC_TIMEOUT, STROBE_LEN);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [CH_W-1:0]   ch;
  logic [CH_W-2:0]   pair;
  logic              pair_done;
  logic              strobe_end;

  assign pair       = ch[CH_W-1:1];
  assign pair_done  = ~eoc_n[pair];
  assign strobe_end = (state == SQ_STROBE) && (cnt == CNT_W'(STROBE_LEN - 1));

  assign hold_n  = (state != SQ_HOLD);
  assign cs_n    = (state != SQ_STROBE);
  assign rd_n    = (state != SQ_STROBE);
  assign cap_en  = strobe_end;
  assign cap_idx = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      cnt         <= '0;
      ch          <= '0;
      err_timeout <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (tick && !occupied) begin
            state       <= SQ_HOLD;
            cnt         <= '0;
            ch          <= '0;
            err_timeout <= 1'b0;
          end
        end
        SQ_HOLD: begin
          if (cnt == CNT_W'(HOLD_MIN - 1)) begin
            state <= SQ_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (pair_done) begin
            state <= SQ_STROBE;
            cnt   <= '0;
          end else if (cnt == CNT_W'(EOC_TIMEOUT - 1)) begin
            state       <= SQ_IDLE;
            cnt         <= '0;
            err_timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_STROBE: begin
          if (strobe_end) begin
            cnt <= '0;
            if (ch == CH_W'(N_CH - 1)) begin
              state <= SQ_IDLE;
            end else begin
              state <= SQ_GAP;
              ch    <= ch + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_GAP: begin
          state <= ch[0] ? SQ_STROBE : SQ_WAIT;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_count <= '0;
    end else if (tick && ((state != SQ_IDLE) || occupied) && (ovr_count != {OVR_W{1'b1}})) begin
      ovr_count <= ovr_count + 1'b1;
    end
  end

  // checker state: length of the current hold-low run
  logic [CNT_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!hold_n) low_run <= (low_run == {CNT_W{1'b1}}) ? low_run : low_run + 1'b1;
    else low_run <= '0;
  end

  assert_hold_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n) |-> $past(tick));

  assert_hold_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_n) |-> (low_run == CNT_W'(HOLD_MIN)));

  assert_hold_cs_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hold_n && !cs_n));

  assert_no_strobe_before_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && eoc_n[pair]) |=> cs_n);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (cs_n && hold_n && !cap_en));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold_n && state != SQ_IDLE) |=> hold_n);
endmodule

// File: rtl/adcseq_frame_buf.sv
module adcseq_frame_buf #(
  parameter int N_CH = 6,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [$clog2(N_CH)-1:0]  cap_idx,
  input  logic [DW-1:0]            din,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [N_CH*DW-1:0]       out_data,
  output logic                     done_pulse
);
  localparam int CH_W = $clog2(N_CH);

  logic [DW-1:0]       shadow [N_CH];
  logic [N_CH*DW-1:0]  next_frame;
  logic                last_cap;

  assign last_cap = cap_en && (cap_idx == CH_W'(N_CH - 1));

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow[g] <= '0;
        else if (cap_en && cap_idx == CH_W'(g)) shadow[g] <= din;
      end
      if (g == N_CH - 1) begin : g_last
        assign next_frame[g*DW +: DW] = din;
      end else begin : g_prev
        assign next_frame[g*DW +: DW] = shadow[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= last_cap;
      if (last_cap) begin
        out_valid <= 1'b1;
        out_data  <= next_frame;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: rtl/sim_adc_sequencer.sv
module sim_adc_sequencer #(
  parameter int TICK_DIV    = 2500000,
  parameter int CONV_HALF   = 25,
  parameter int HOLD_MIN    = 4,
  parameter int EOC_TIMEOUT = 2000,
  parameter int STROBE_LEN  = 3,
  parameter int OVR_W       = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   adc_eoc_n,
  input  logic [15:0]  adc_data,
  output logic         adc_hold_n,
  output logic         adc_cs_n,
  output logic         adc_rd_n,
  output logic         adc_conv_clk,
  output logic         frm_valid,
  input  logic         frm_ready,
  output logic [95:0]  frm_data,
  output logic         frm_done,
  output logic         err_timeout,
  output logic [OVR_W-1:0] ovr_count
);
  localparam int N_CH = 6;
  localparam int DW   = 16;
  localparam int CH_W = $clog2(N_CH);

  logic            tick;
  logic            cap_en;
  logic [CH_W-1:0] cap_idx;

  adcseq_rate_gen #(.DIV(TICK_DIV), .SQUARE(1'b0)) u_tick (
    .clk(clk), .rst_n(rst_n), .out(tick));

  adcseq_rate_gen #(.DIV(CONV_HALF), .SQUARE(1'b1)) u_conv (
    .clk(clk), .rst_n(rst_n), .out(adc_conv_clk));

  adcseq_ctrl #(
    .N_CH(N_CH), .HOLD_MIN(HOLD_MIN), .EOC_TIMEOUT(EOC_TIMEOUT),
    .STROBE_LEN(STROBE_LEN), .OVR_W(OVR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .occupied(frm_valid),
    .eoc_n(adc_eoc_n), .hold_n(adc_hold_n), .cs_n(adc_cs_n), .rd_n(adc_rd_n),
    .cap_en(cap_en), .cap_idx(cap_idx), .err_timeout(err_timeout),
    .ovr_count(ovr_count));

  adcseq_frame_buf #(.N_CH(N_CH), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .din(adc_data), .out_ready(frm_ready), .out_valid(frm_valid),
    .out_data(frm_data), .done_pulse(frm_done));
endmodule

// File: tb/sim_adc_sequencer_tb_top.sv
module sim_adc_sequencer_tb_top;
  localparam int TICK_DIV = 400;
  localparam int CONV_H   = 3;
  localparam int HOLD_M   = 3;
  localparam int EOC_TO   = 300;
  localparam int STR_LEN  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] adc_eoc_n = 3'b111;
  logic [15:0] adc_data = '0;
  logic adc_hold_n, adc_cs_n, adc_rd_n, adc_conv_clk;
  logic frm_valid, frm_done, err_timeout;
  logic frm_ready = 1'b1;
  logic [95:0] frm_data;
  logic [7:0] ovr_count;

  always #2 clk = ~clk;

  sim_adc_sequencer #(
    .TICK_DIV(TICK_DIV), .CONV_HALF(CONV_H), .HOLD_MIN(HOLD_M),
    .EOC_TIMEOUT(EOC_TO), .STROBE_LEN(STR_LEN), .OVR_W(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .adc_eoc_n(adc_eoc_n), .adc_data(adc_data),
    .adc_hold_n(adc_hold_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_conv_clk(adc_conv_clk), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_data(frm_data), .frm_done(frm_done), .err_timeout(err_timeout),
    .ovr_count(ovr_count));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int k);
    return seed + 16'(16'h1357 * (k + 1));
  endfunction

  // converter model and monitors, evaluated at the falling edge
  logic [11:0] dly [3];
  logic [15:0] seed_cur = '0;
  int  since_hold = 0;
  int  rd_idx = -1;
  int  hold_falls = 0;
  logic prev_hold = 1'b1, prev_cs = 1'b1, prev_conv = 1'b0;
  int  hold_run = 0, cs_run = 0, last_conv_rise = -1, conv_rises = 0;
  int  v_hold_w = 0, v_excl = 0, v_eoc = 0, v_pair = 0, v_sw = 0, v_conv = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_hold && !adc_hold_n) begin
      since_hold = 0;
      rd_idx = -1;
      hold_falls++;
    end else begin
      since_hold++;
    end
    if (!adc_hold_n) hold_run++;
    if (!prev_hold && adc_hold_n) begin
      if (hold_run != HOLD_M) v_hold_w++;
      hold_run = 0;
    end
    if (!adc_cs_n && !adc_hold_n) v_excl++;
    if (adc_cs_n != adc_rd_n) v_pair++;
    if (prev_cs && !adc_cs_n) begin
      rd_idx++;
      if (rd_idx > 5 || adc_eoc_n[rd_idx/2] != 1'b0) v_eoc++;
      adc_data = word_of(seed_cur, rd_idx);
    end
    if (!adc_cs_n) cs_run++;
    if (!prev_cs && adc_cs_n) begin
      if (cs_run != STR_LEN) v_sw++;
      cs_run = 0;
    end
    if (!prev_conv && adc_conv_clk) begin
      if (last_conv_rise >= 0 && (cyc - last_conv_rise) != 2 * CONV_H) v_conv++;
      last_conv_rise = cyc;
      conv_rises++;
    end
    for (int p = 0; p < 3; p++) adc_eoc_n[p] = !(since_hold >= int'(dly[p]));
    prev_hold = adc_hold_n;
    prev_cs   = adc_cs_n;
    prev_conv = adc_conv_clk;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // d0, d1, d2 (12 bits each), seed (16), kind (2): 0 good, 1 timeout, 2 overrun
  localparam int NV = 7;
  localparam logic [53:0] VEC [NV] = '{
    {12'd5,  12'd20,  12'd40,   16'hA5A5, 2'd0},
    {12'd2,  12'd3,   12'd4,    16'h1234, 2'd0},
    {12'd60, 12'd61,  12'd62,   16'h0F0F, 2'd0},
    {12'd10, 12'd30,  12'd2000, 16'hBEEF, 2'd1},
    {12'd8,  12'd18,  12'd28,   16'h7777, 2'd0},
    {12'd10, 12'd250, 12'd480,  16'hC3C3, 2'd2},
    {12'd4,  12'd14,  12'd24,   16'h5A5A, 2'd0}
  };

  initial begin : watchdog
    #(4 * 40000);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [95:0] last_frame;
    logic [95:0] exp_frame;
    int t_prev;
    int prev_kind;
    int ovr_prev;
    int hf;
    bit seen_done, seen_err;
    dly[0] = 12'd5; dly[1] = 12'd10; dly[2] = 12'd15;
    repeat (5) step();
    // R1 reset state
    chk(adc_hold_n && adc_cs_n && adc_rd_n, "R1", "reset strobes high", {adc_hold_n, adc_cs_n, adc_rd_n}, 3'b111);
    chk(!frm_valid && !frm_done && !err_timeout, "R1", "reset flags low", {frm_valid, frm_done, err_timeout}, 0);
    chk(ovr_count == 0, "R1", "reset overrun count", ovr_count, 0);
    rst_n = 1'b1;
    last_frame = '0;
    t_prev = -1;
    prev_kind = -1;

    for (int i = 0; i < NV; i++) begin
      dly[0]   = VEC[i][53:42];
      dly[1]   = VEC[i][41:30];
      dly[2]   = VEC[i][29:18];
      seed_cur = VEC[i][17:2];
      ovr_prev = ovr_count;
      hf = hold_falls;
      for (int w = 0; w < 1200 && hold_falls == hf; w++) step();
      if (prev_kind == 0 || prev_kind == 1)
        chk(cyc - t_prev == TICK_DIV, "R1", "frame start spacing", cyc - t_prev, TICK_DIV);
      else if (prev_kind == 2)
        chk(cyc - t_prev == 2 * TICK_DIV, "R9", "no start while busy, spacing", cyc - t_prev, 2 * TICK_DIV);
      if (prev_kind == 1)
        chk(!err_timeout, "R8", "error clears at next hold", err_timeout, 0);
      t_prev = cyc;
      seen_done = 1'b0;
      seen_err = 1'b0;
      for (int w = 0; w < 700 && !seen_done && !seen_err; w++) begin
        step();
        seen_done = frm_done;
        seen_err = err_timeout;
      end
      for (int k = 0; k < 6; k++) exp_frame[16*k +: 16] = word_of(seed_cur, k);
      if (VEC[i][1:0] == 2'd1) begin
        chk(seen_err && !seen_done, "R8", "timeout abort", {seen_err, seen_done}, 2'b10);
        repeat (20) step();
        chk(frm_data == last_frame, "R8", "frame kept after abort", frm_data[15:0], last_frame[15:0]);
        chk(rd_idx == 3, "R8", "strobes stop at aborted pair", rd_idx, 3);
        chk(!frm_done && err_timeout, "R8", "no done, flag held", {frm_done, err_timeout}, 2'b01);
      end else begin
        chk(seen_done && frm_valid, "R6", "done with valid", {seen_done, frm_valid}, 2'b11);
        chk(frm_data == exp_frame, "R5", "frame words and order", frm_data, exp_frame);
        chk(rd_idx == 5, "R4", "six strobes per frame", rd_idx + 1, 6);
        last_frame = frm_data;
        step();
        chk(!frm_done, "R6", "done lasts one clock", frm_done, 0);
        if (VEC[i][1:0] == 2'd2) begin
          repeat (5) step();
          chk(ovr_count == ovr_prev + 1, "R9", "overrun counted", ovr_count, ovr_prev + 1);
        end
      end
      prev_kind = VEC[i][1:0];
    end

    // R7 back-pressure
    frm_ready = 1'b0;
    dly[0] = 12'd6; dly[1] = 12'd12; dly[2] = 12'd18;
    seed_cur = 16'h3C3C;
    hf = hold_falls;
    for (int w = 0; w < 1200 && hold_falls == hf; w++) step();
    seen_done = 1'b0;
    for (int w = 0; w < 300 && !seen_done; w++) begin
      step();
      seen_done = frm_done;
    end
    for (int k = 0; k < 6; k++) exp_frame[16*k +: 16] = word_of(seed_cur, k);
    chk(seen_done && frm_data == exp_frame, "R7", "frame under stall", frm_data, exp_frame);
    ovr_prev = ovr_count;
    hf = hold_falls;
    repeat (450) step();
    chk(frm_valid && frm_data == exp_frame, "R7", "valid and data held", frm_valid, 1);
    chk(hold_falls == hf, "R7", "no frame while occupied", hold_falls - hf, 0);
    chk(ovr_count == ovr_prev + 1, "R9", "stalled trigger counted", ovr_count, ovr_prev + 1);
    frm_ready = 1'b1;
    step();
    step();
    chk(!frm_valid, "R7", "valid drops after handover", frm_valid, 0);

    chk(v_hold_w == 0, "R2", "hold width violations", v_hold_w, 0);
    chk(v_excl == 0, "R2", "select during hold", v_excl, 0);
    chk(v_eoc == 0, "R3", "strobe before pair done", v_eoc, 0);
    chk(v_pair == 0, "R4", "select/read mismatch", v_pair, 0);
    chk(v_sw == 0, "R4", "strobe width violations", v_sw, 0);
    chk(v_conv == 0 && conv_rises > 10, "R10", "conversion clock period", v_conv, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule